// File: doc/BRIEF.md
# Packed SIMD Integer ALU

This unit applies one integer operation to every lane of a 64-bit vector in parallel. A lane-size select splits both operands into eight 8-bit lanes, four 16-bit lanes or two 32-bit lanes. Carries and borrows are cut at the lane edges, so no lane disturbs its neighbour, and each lane saturates on its own bounds when saturation is requested. Compares do not set flags. Each lane of the result becomes an all-ones or all-zeros mask, and that mask can be ANDed with a data vector to make a lane-wise conditional assignment.

The instruction form has two addresses. Operand `dst_a` is the destination's old value and is the first source. Operand `src_b` is the second source. The caller presents an opcode, a lane size, a signed flag, a saturate flag and both operands together with `in_valid`. The registered result appears on the next clock edge, and `out_done` is high for that one cycle. The block has no back-pressure. It accepts an operation on every cycle that `in_valid` is high, and the consumer must take the result in the cycle `out_done` is high, because the next accepted operation overwrites it.

Top module: `simd_alu`

## Requirements
- R1: With opcode 3'd0 (add) and saturation off, each lane of the result is (a + b) mod 2^W. W is 8, 16 or 32 for lane size 2'b00, 2'b01 or 2'b10. No carry passes between lanes.
- R2: With opcode 3'd1 (subtract) and saturation off, each lane of the result is (a - b) mod 2^W. No borrow passes between lanes.
- R3: With opcode 3'd0 or 3'd1, saturation on and the signed flag set, each lane is computed in two's complement. A lane result above 2^(W-1)-1 is clamped to that value, and a result below -2^(W-1) is clamped to -2^(W-1).
- R4: With opcode 3'd0 or 3'd1, saturation on and the signed flag clear, a lane result above 2^W-1 is clamped to 2^W-1, and a result below 0 is clamped to 0.
- R5: Opcode 3'd2 (equality) writes all ones to each lane where the two lanes are equal and all zeros elsewhere. The signed and saturate flags have no effect.
- R6: Opcode 3'd3 (greater-than) writes all ones to each lane where lane a is greater than lane b as two's complement numbers, and all zeros elsewhere.
- R7: Opcodes 3'd4, 3'd5, 3'd6 and 3'd7 give a AND b, (NOT a) AND b, a OR b and a XOR b over all 64 bits. The signed and saturate flags and the three valid lane sizes have no effect on them.
- R8: Lane size 2'b11 is reserved. Any operation given with it produces a zero result.
- R9: The result register loads only in a cycle where `in_valid` is high. `out_done` is high in exactly the cycle after each such input cycle and low after a cycle with `in_valid` low, and the result holds its value while no operation is accepted.
- R10: While reset is active and after reset, before any operation, `out_done` is 0 and `out_result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Accept the operation this cycle |
| op | input | 3 | Opcode (see R1 to R7) |
| lane_sel | input | 2 | Lane size: 00 = 8, 01 = 16, 10 = 32 bits, 11 reserved |
| is_signed | input | 1 | Treat lanes as two's complement for saturation |
| saturate | input | 1 | Clamp add/subtract results instead of wrapping |
| dst_a | input | 64 | First source and destination's old value |
| src_b | input | 64 | Second source |
| out_done | output | 1 | One-cycle pulse marking a new result |
| out_result | output | 64 | Registered result |

## Verification
The bench sweeps every opcode, every lane size including the reserved one, and both settings of each flag. The operand set combines an 8x8 grid of corner vectors with pseudo-random pairs. Vectors of all ones and of 0x7F.../0x80... bytes sit at the lane limits, so they separate wrapping from clamping at each bound and show whether a carry leaks into the next lane. Equal and near-equal pairs separate the equality mask from the greater-than mask, and mixed-sign pairs show whether greater-than is signed. An idle cycle with changed inputs after each operation shows that the result holds and that `out_done` falls. A back-to-back pair shows that `out_done` stays high for consecutive operations.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_CEQ  = 3'd2,
    OP_CGT  = 3'd3,
    OP_AND  = 3'd4,
    OP_ANDN = 3'd5,
    OP_OR   = 3'd6,
    OP_XOR  = 3'd7
  } simd_op_e;

  typedef enum logic [1:0] {
    LS_8   = 2'b00,
    LS_16  = 2'b01,
    LS_32  = 2'b10,
    LS_RSV = 2'b11
  } lane_size_e;

  localparam int MIN_LANE_W = 8;
  localparam int N_SIZES    = 3;
endpackage

// File: rtl/simd_lane.sv
module simd_lane
  import simd_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  simd_op_e     op,
  input  logic         is_signed,
  input  logic         saturate,
  output logic [W-1:0] res
);
  logic [W:0]   ext_a, ext_b, wide;
  logic         ovf;
  logic [W-1:0] clamp, arith;

  always_comb begin
    ext_a = is_signed ? {a[W-1], a} : {1'b0, a};
    ext_b = is_signed ? {b[W-1], b} : {1'b0, b};
    wide  = (op == OP_SUB) ? (ext_a - ext_b) : (ext_a + ext_b);
    if (is_signed) begin
      ovf   = wide[W] ^ wide[W-1];
      clamp = wide[W] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
    end else begin
      ovf   = wide[W];
      clamp = (op == OP_SUB) ? '0 : '1;
    end
    arith = (saturate && ovf) ? clamp : wide[W-1:0];
    case (op)
      OP_ADD, OP_SUB: res = arith;
      OP_CEQ:         res = {W{a == b}};
      OP_CGT:         res = {W{$signed(a) > $signed(b)}};
      default:        res = '0;
    endcase
  end

  always_comb begin
    if (op == OP_CEQ || op == OP_CGT)
      assert_mask_full_R5: assert (res == '0 || res == '1)
        else $error("compare lane is not a full mask");
    if (op == OP_ADD && saturate && !is_signed)
      assert_usat_nowrap_R4: assert (res >= a)
        else $error("unsigned saturating add wrapped");
  end
endmodule

// File: rtl/simd_lane_array.sv
module simd_lane_array
  import simd_alu_pkg::*;
#(
  parameter int VEC_W  = 64,
  parameter int LANE_W = 8
) (
  input  logic [VEC_W-1:0] a,
  input  logic [VEC_W-1:0] b,
  input  simd_op_e         op,
  input  logic             is_signed,
  input  logic             saturate,
  output logic [VEC_W-1:0] res
);
  localparam int N_LANES = VEC_W / LANE_W;

  for (genvar i = 0; i < N_LANES; i++) begin : g_lane
    simd_lane #(.W(LANE_W)) u_lane (
      .a         (a[i*LANE_W +: LANE_W]),
      .b         (b[i*LANE_W +: LANE_W]),
      .op        (op),
      .is_signed (is_signed),
      .saturate  (saturate),
      .res       (res[i*LANE_W +: LANE_W])
    );
  end
endmodule

// File: rtl/simd_alu.sv
module simd_alu
  import simd_alu_pkg::*;
#(
  parameter int VEC_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [2:0]       op,
  input  logic [1:0]       lane_sel,
  input  logic             is_signed,
  input  logic             saturate,
  input  logic [VEC_W-1:0] dst_a,
  input  logic [VEC_W-1:0] src_b,
  output logic             out_done,
  output logic [VEC_W-1:0] out_result
);
  simd_op_e         op_e;
  lane_size_e       ls_e;
  logic [VEC_W-1:0] by_size [N_SIZES];
  logic [VEC_W-1:0] next_result;

  assign op_e = simd_op_e'(op);
  assign ls_e = lane_size_e'(lane_sel);

  for (genvar g = 0; g < N_SIZES; g++) begin : g_size
    simd_lane_array #(.VEC_W(VEC_W), .LANE_W(MIN_LANE_W << g)) u_arr (
      .a         (dst_a),
      .b         (src_b),
      .op        (op_e),
      .is_signed (is_signed),
      .saturate  (saturate),
      .res       (by_size[g])
    );
  end

  always_comb begin
    next_result = '0;
    if (ls_e != LS_RSV) begin
      case (op_e)
        OP_AND:  next_result = dst_a & src_b;
        OP_ANDN: next_result = ~dst_a & src_b;
        OP_OR:   next_result = dst_a | src_b;
        OP_XOR:  next_result = dst_a ^ src_b;
        default: begin
          case (ls_e)
            LS_8:    next_result = by_size[0];
            LS_16:   next_result = by_size[1];
            LS_32:   next_result = by_size[2];
            default: next_result = '0;
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_done   <= 1'b0;
      out_result <= '0;
    end else begin
      out_done <= in_valid;
      if (in_valid) out_result <= next_result;
    end
  end

  assert_done_after_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_done) else $error("done missing after valid");
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_done) else $error("done without valid");
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_result)) else $error("result moved while idle");
  assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && lane_sel == 2'b11) |=> out_result == '0) else $error("reserved size not zero");
endmodule

// File: tb/simd_alu_tb.sv
module simd_alu_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  op;
  logic [1:0]  lane_sel;
  logic        is_signed, saturate;
  logic [63:0] dst_a, src_b;
  logic        out_done;
  logic [63:0] out_result;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

  simd_alu u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .lane_sel(lane_sel),
    .is_signed(is_signed), .saturate(saturate), .dst_a(dst_a), .src_b(src_b),
    .out_done(out_done), .out_result(out_result)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected below %0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  function automatic logic [63:0] next_rand();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 7);
    rng = rng ^ (rng << 17);
    return rng;
  endfunction

  function automatic string req_tag(input logic [2:0] o, input logic [1:0] ls,
                                    input logic sg, input logic st);
    if (ls == 2'b11) return "R8";
    case (o)
      3'd0, 3'd1: begin
        if (st && sg) return "R3";
        if (st)       return "R4";
        return (o == 3'd0) ? "R1" : "R2";
      end
      3'd2:    return "R5";
      3'd3:    return "R6";
      default: return "R7";
    endcase
  endfunction

  function automatic logic [63:0] model(input logic [2:0] o, input logic [1:0] ls,
                                        input logic sg, input logic st,
                                        input logic [63:0] a, input logic [63:0] b);
    logic [63:0] r;
    int w;
    longint mask, ua, ub, sa, sb, x, y, v, lo, hi;
    r = '0;
    if (ls == 2'b11) return '0;
    case (o)
      3'd4: return a & b;
      3'd5: return ~a & b;
      3'd6: return a | b;
      3'd7: return a ^ b;
      default: ;
    endcase
    w = 8 << ls;
    mask = (longint'(1) << w) - 1;
    for (int i = 0; i < 64 / w; i++) begin
      ua = longint'(a >> (i * w)) & mask;
      ub = longint'(b >> (i * w)) & mask;
      sa = (ua >= (longint'(1) << (w - 1))) ? ua - (longint'(1) << w) : ua;
      sb = (ub >= (longint'(1) << (w - 1))) ? ub - (longint'(1) << w) : ub;
      if (sg) begin
        x = sa; y = sb; lo = -(longint'(1) << (w - 1)); hi = (longint'(1) << (w - 1)) - 1;
      end else begin
        x = ua; y = ub; lo = 0; hi = mask;
      end
      case (o)
        3'd0:    v = x + y;
        3'd1:    v = x - y;
        3'd2:    v = (ua == ub) ? mask : 0;
        default: v = (sa > sb) ? mask : 0;
      endcase
      if (st && o < 3'd2) begin
        if (v > hi) v = hi;
        if (v < lo) v = lo;
      end
      r = r | (64'(v & mask) << (i * w));
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One operation, then one idle cycle with disturbed inputs (R9 hold).
  task automatic run_op(input logic [2:0] o, input logic [1:0] ls, input logic sg,
                        input logic st, input logic [63:0] a, input logic [63:0] b);
    logic [63:0] exp;
    exp = model(o, ls, sg, st, a, b);
    op = o; lane_sel = ls; is_signed = sg; saturate = st; dst_a = a; src_b = b;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R9", {63'd0, out_done}, 64'd1);
    check(req_tag(o, ls, sg, st), out_result, exp);
    in_valid = 1'b0;
    dst_a = ~a; src_b = next_rand(); op = ~o;
    @(posedge clk);
    @(negedge clk);
    check("R9", {63'd0, out_done}, 64'd0);
    check("R9", out_result, exp);
  endtask

  logic [63:0] corner [8];

  initial begin
    corner[0] = 64'h0000_0000_0000_0000;
    corner[1] = 64'hFFFF_FFFF_FFFF_FFFF;
    corner[2] = 64'h7F7F_7F7F_7F7F_7F7F;
    corner[3] = 64'h8080_8080_8080_8080;
    corner[4] = 64'h0101_0101_0101_0101;
    corner[5] = 64'h7FFF_FFFF_8000_0001;
    corner[6] = 64'h00FF_7F80_FF00_807F;
    corner[7] = 64'h1234_5678_9ABC_DEF0;

    in_valid = 1'b0; op = '0; lane_sel = '0; is_signed = 1'b0; saturate = 1'b0;
    dst_a = '0; src_b = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", {63'd0, out_done}, 64'd0);
    check("R10", out_result, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", {63'd0, out_done}, 64'd0);
    check("R10", out_result, 64'd0);

    for (int o = 0; o < 8; o++)
      for (int ls = 0; ls < 4; ls++)
        for (int sg = 0; sg < 2; sg++)
          for (int st = 0; st < 2; st++) begin
            for (int i = 0; i < 8; i++)
              for (int j = 0; j < 8; j++)
                run_op(3'(o), 2'(ls), 1'(sg), 1'(st), corner[i], corner[j]);
            for (int k = 0; k < 16; k++)
              run_op(3'(o), 2'(ls), 1'(sg), 1'(st), next_rand(), next_rand());
          end

    // R9: back-to-back operations keep done high on consecutive cycles
    op = 3'd0; lane_sel = 2'b00; is_signed = 1'b0; saturate = 1'b0;
    dst_a = 64'h0102_0304_0506_0708; src_b = 64'h0101_0101_0101_0101;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R9", {63'd0, out_done}, 64'd1);
    check("R1", out_result, 64'h0203_0405_0607_0809);
    op = 3'd7; dst_a = 64'hFFFF_0000_FFFF_0000; src_b = 64'h0F0F_0F0F_0F0F_0F0F;
    @(posedge clk);
    @(negedge clk);
    check("R9", {63'd0, out_done}, 64'd1);
    check("R7", out_result, 64'hF0F0_0F0F_F0F0_0F0F);
    in_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R9", {63'd0, out_done}, 64'd0);

    // R3 spot value: signed byte 0x7F + 0x01 clamps to 0x7F; 0x80 - 0x01 clamps to 0x80
    run_op(3'd0, 2'b00, 1'b1, 1'b1, 64'h7F, 64'h01);
    check("R3", out_result, 64'h7F);
    run_op(3'd1, 2'b00, 1'b1, 1'b1, 64'h80, 64'h01);
    check("R3", out_result, 64'h80);
    // R4 spot value: unsigned 16-bit 0xFFFF + 1 clamps; 0 - 1 clamps to 0
    run_op(3'd0, 2'b01, 1'b0, 1'b1, 64'hFFFF, 64'h1);
    check("R4", out_result, 64'hFFFF);
    run_op(3'd1, 2'b01, 1'b0, 1'b1, 64'h0, 64'h1);
    check("R4", out_result, 64'h0);
    // R1 spot value: 8-bit wrap does not carry into lane 1
    run_op(3'd0, 2'b00, 1'b0, 1'b0, 64'hFF, 64'h01);
    check("R1", out_result, 64'h0);

    finish_run();
  end
endmodule